// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break Recovery

This block receives asynchronous serial characters on a single line. It is clocked by the system clock and advances by one step on each pulse of an oversampling tick that runs at sixteen times the bit rate. A falling line seen on a tick starts a character. The block validates the start bit at its centre and then assembles 8 or 9 data bits, least significant first. It can check an optional parity bit and then samples one stop bit. Each finished word, together with its own error flags, goes into a two-slot queue. The oldest slot is always visible on the read port.

A break holds the line low for a long time. The block accepts it as one all-zero character with a framing error. It then refuses to look for a new start bit until it has seen the line high again. When a third character completes while both slots are occupied, the block raises an overrun flag. The queued words are kept and the new word is dropped. Overrun is cleared only by a status read followed later by a data read. An interrupt output combines the interrupt enable with the data-available and overrun flags.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, idle=1, avail=0, ferr=0, perr=0, nf=0, oerr=0, irq=0 and rdata=0.
- R2: A character is a low start bit, then 8 data bits (cfg_nine=0) or 9 data bits (cfg_nine=1) sent least significant first, then an optional parity bit, then one stop bit. Each bit lasts 16 ticks. The word appears on rdata[8:0], and rdata[8] is 0 in 8-bit mode.
- R3: Each bit is decided by a majority of the line at its tick indices 7, 8 and 9, where index 0 is the tick on which the start was detected. nf is set for a character in which any bit's three samples disagree. A start bit whose majority is high returns the receiver to idle and stores no character.
- R4: With cfg_par_en=1, a parity bit follows the data. cfg_par_odd=0 expects an even count of ones over the data and parity bits, and cfg_par_odd=1 expects an odd count. A mismatch sets perr for that character.
- R5: A stop bit whose majority is low sets ferr for that character.
- R6: A line held low is accepted as exactly one character. It completes at the stop-bit centre with data 0 and ferr=1. No further start bit is searched for until the line is seen high on a tick.
- R7: idle falls on the tick that detects a start bit and rises at the stop-bit centre. It stays high while a break is still holding the line low.
- R8: The queue holds two characters. rdata, ferr, perr and nf show the oldest character, and they read 0 when the queue is empty. avail=1 when the queue is non-empty. A data_rd pulse removes the oldest character.
- R9: A character that completes while two are queued sets oerr. Both queued characters stay unchanged and the new one is discarded.
- R10: oerr clears only on a data_rd that follows a stat_rd made while oerr was set. A data_rd without such a stat_rd leaves oerr set.
- R11: irq = rie AND (avail OR oerr).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, already synchronous to clk |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 adds a parity bit after the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rie | input | 1 | Receive interrupt enable |
| stat_rd | input | 1 | One-cycle status read strobe |
| data_rd | input | 1 | One-cycle data read strobe, removes the oldest character |
| rdata | output | 9 | Oldest queued character |
| idle | output | 1 | Receiver is between characters |
| avail | output | 1 | Queue holds at least one character |
| ferr | output | 1 | Framing error of the oldest character |
| perr | output | 1 | Parity error of the oldest character |
| nf | output | 1 | Noise seen in the oldest character |
| oerr | output | 1 | Overrun occurred |
| irq | output | 1 | Receive interrupt |

## Verification
The bench holds the line low for several bit times past the stop position and then checks three things. It expects one zero character with ferr, and idle already high while the line is still low. It also checks that a second character never appears. A receiver that resynchronizes on the low line would show idle low or a phantom second entry. A third character is sent into a full queue; a design that overwrote a slot would show the wrong second word after the first read. A data read without a prior status read must leave oerr set, which catches a clear on any data read. Further cases cover a one-tick glitch that must set nf without corrupting the data, a short start pulse that must be dropped, and wrong parity against correct parity in both senses.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int RX_WMAX = 9;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_t;

  typedef struct packed {
    logic               nf;
    logic               perr;
    logic               ferr;
    logic [RX_WMAX-1:0] data;
  } rx_entry_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic disagree3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction

  function automatic logic parity_bad(input logic [RX_WMAX-1:0] w, input logic p,
                                      input logic odd);
    return (^w) ^ p ^ odd;
  endfunction
endpackage

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick16,
  input  logic               rxd,
  input  logic               cfg_nine,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  output logic               done,
  output rx_entry_t          done_entry,
  output logic               idle,
  output logic               brk_wait
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(RX_WMAX);
  localparam logic [CW-1:0] T_A   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] T_B   = CW'(OVS / 2);
  localparam logic [CW-1:0] T_C   = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] T_END = CW'(OVS - 1);

  rx_state_t          st;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bidx;
  logic [RX_WMAX-1:0] sh;
  logic               s_a, s_b, pbit, nacc;
  logic               vote, noisy;
  logic [BW-1:0]      last_bit;

  assign vote     = maj3(s_a, s_b, rxd);
  assign noisy    = disagree3(s_a, s_b, rxd);
  assign last_bit = cfg_nine ? BW'(RX_WMAX - 1) : BW'(RX_WMAX - 2);
  assign idle     = (st == RX_IDLE) || (st == RX_HOLD);
  assign brk_wait = (st == RX_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      sh         <= '0;
      s_a        <= 1'b1;
      s_b        <= 1'b1;
      pbit       <= 1'b0;
      nacc       <= 1'b0;
      done       <= 1'b0;
      done_entry <= '0;
    end else begin
      done <= 1'b0;
      if (tick16) begin
        case (st)
          RX_IDLE: begin
            if (!rxd) begin
              st   <= RX_START;
              cnt  <= CW'(1);
              bidx <= '0;
              sh   <= '0;
              nacc <= 1'b0;
            end
          end
          RX_HOLD: begin
            if (rxd) st <= RX_IDLE;
          end
          default: begin
            cnt <= (cnt == T_END) ? '0 : cnt + CW'(1);
            if (cnt == T_A) s_a <= rxd;
            if (cnt == T_B) s_b <= rxd;
            if (cnt == T_C) begin
              nacc <= nacc | noisy;
              case (st)
                RX_START: if (vote) st <= RX_IDLE;
                RX_DATA:  sh[bidx] <= vote;
                RX_PAR:   pbit <= vote;
                RX_STOP: begin
                  done            <= 1'b1;
                  done_entry.data <= sh;
                  done_entry.ferr <= !vote;
                  done_entry.perr <= cfg_par_en && parity_bad(sh, pbit, cfg_par_odd);
                  done_entry.nf   <= nacc | noisy;
                  st              <= vote ? RX_IDLE : RX_HOLD;
                end
                default: ;
              endcase
            end
            if (cnt == T_END) begin
              case (st)
                RX_START: st <= RX_DATA;
                RX_DATA: begin
                  if (bidx == last_bit) st <= cfg_par_en ? RX_PAR : RX_STOP;
                  else bidx <= bidx + BW'(1);
                end
                RX_PAR:  st <= RX_STOP;
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_fifo2.sv
module rx_fifo2
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic      rd,
  input  rx_entry_t din,
  output rx_entry_t head,
  output logic [1:0] count
);
  rx_entry_t slot0, slot1;

  assign head = slot0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
      count <= 2'd0;
    end else begin
      case ({wr, rd})
        2'b10: begin
          if (count == 2'd0) slot0 <= din;
          else slot1 <= din;
          count <= count + 2'd1;
        end
        2'b01: begin
          slot0 <= slot1;
          count <= count - 2'd1;
        end
        2'b11: begin
          if (count == 2'd1) slot0 <= din;
          else begin
            slot0 <= slot1;
            slot1 <= din;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_ovr_ctl.sv
module rx_ovr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic stat_rd,
  input  logic data_rd,
  output logic oerr
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oerr  <= 1'b0;
      armed <= 1'b0;
    end else if (ovr_evt) begin
      oerr  <= 1'b1;
      armed <= 1'b0;
    end else if (data_rd && armed) begin
      oerr  <= 1'b0;
      armed <= 1'b0;
    end else if (stat_rd && oerr) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick16,
  input  logic               rxd,
  input  logic               cfg_nine,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  input  logic               rie,
  input  logic               stat_rd,
  input  logic               data_rd,
  output logic [RX_WMAX-1:0] rdata,
  output logic               idle,
  output logic               avail,
  output logic               ferr,
  output logic               perr,
  output logic               nf,
  output logic               oerr,
  output logic               irq
);
  logic       done, push, pop, full, ovr_evt, brk_wait;
  rx_entry_t  done_entry, head;
  logic [1:0] count;

  uart_rx_engine #(.OVS(OVS)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .done(done), .done_entry(done_entry), .idle(idle), .brk_wait(brk_wait)
  );

  assign avail   = (count != 2'd0);
  assign full    = (count == 2'd2);
  assign pop     = data_rd && avail;
  assign push    = done && (!full || pop);
  assign ovr_evt = done && full && !pop;

  rx_fifo2 u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(push), .rd(pop), .din(done_entry),
    .head(head), .count(count)
  );

  rx_ovr_ctl u_ovr (
    .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .stat_rd(stat_rd),
    .data_rd(data_rd), .oerr(oerr)
  );

  assign rdata = avail ? head.data : '0;
  assign ferr  = avail && head.ferr;
  assign perr  = avail && head.perr;
  assign nf    = avail && head.nf;
  assign irq   = rie && (avail || oerr);
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       rxd,
  input logic       rie,
  input logic       data_rd,
  input logic       idle,
  input logic       avail,
  input logic       oerr,
  input logic       irq,
  input logic [8:0] rdata,
  input logic       ovr_evt,
  input logic       push,
  input logic       brk_wait
);
  assert_ovr_keeps_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !data_rd) |=> ($stable(rdata) && avail));

  assert_ovr_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr) |-> $past(ovr_evt));

  assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oerr) |-> $past(data_rd));

  assert_no_resync_in_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> !$past(brk_wait));

  assert_start_on_low_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> ($past(tick16) && !$past(rxd)));

  assert_push_sets_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> avail);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rie |-> !irq);
endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rie(rie),
  .data_rd(data_rd), .idle(idle), .avail(avail), .oerr(oerr), .irq(irq),
  .rdata(rdata), .ovr_evt(ovr_evt), .push(push), .brk_wait(brk_wait)
);

// File: tb/sim_uart_rx_brk.sv
`timescale 1ns/1ps
module sim_uart_rx_brk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic rie = 1'b1, stat_rd = 1'b0, data_rd = 1'b0;
  logic [8:0] rdata;
  logic idle, avail, ferr, perr, nf, oerr, irq;

  int checks = 0;
  int failures = 0;
  int irq_bad = 0;
  bit finished = 0;
  event tick_done;

  // model state: entries are {nf, perr, ferr, data[8:0]}
  logic [11:0] mq[$];
  bit moerr = 0;
  bit marm = 0;

  uart_rx_brk u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rie(rie), .stat_rd(stat_rd), .data_rd(data_rd), .rdata(rdata),
    .idle(idle), .avail(avail), .ferr(ferr), .perr(perr), .nf(nf),
    .oerr(oerr), .irq(irq)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      -> tick_done;
    end
  end

  // interrupt compared with the requirement on every clock, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n && (irq !== (rie && (avail || oerr)))) irq_bad++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(tick_done);
  endtask

  task automatic compare_model(input string req);
    logic [11:0] e;
    e = (mq.size() > 0) ? mq[0] : 12'h000;
    chk(req, "avail", avail, mq.size() > 0);
    chk(req, "rdata", rdata, e[8:0]);
    chk(req, "ferr", ferr, e[9]);
    chk(req, "perr", perr, e[10]);
    chk(req, "nf", nf, e[11]);
    chk(req, "oerr", oerr, moerr);
  endtask

  task automatic model_push(input logic [11:0] e);
    if (mq.size() == 2) moerr = 1;
    else mq.push_back(e);
  endtask

  task automatic rd_data();
    @(negedge clk);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    if (mq.size() > 0) void'(mq.pop_front());
    if (marm) moerr = 0;
    marm = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    if (moerr) marm = 1;
  endtask

  // glitch_at: bit position (0 = start) whose tick index 8 is inverted, -1 = none
  task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                            input int glitch_at);
    int nd;
    int nb;
    logic [8:0] dm;
    logic [11:0] bits;
    logic p;
    nd = cfg_nine ? 9 : 8;
    dm = cfg_nine ? d : {1'b0, d[7:0]};
    p = 1'b0;
    for (int k = 0; k < 9; k++) p = p ^ dm[k];
    p = p ^ cfg_par_odd ^ bad_par;
    bits = '0;
    bits[0] = 1'b0;
    for (int k = 0; k < nd; k++) bits[k + 1] = dm[k];
    nb = nd + 1;
    if (cfg_par_en) begin
      bits[nb] = p;
      nb++;
    end
    bits[nb] = !bad_stop;
    nb++;
    for (int i = 0; i < nb; i++) begin
      for (int t = 0; t < 16; t++) begin
        rxd = (i == glitch_at && t == 8) ? !bits[i] : bits[i];
        if (i == 3 && t == 0) chk("R7", "idle mid-frame", idle, 0);
        @(tick_done);
      end
    end
    rxd = 1'b1;
    ticks(32);
    model_push({(glitch_at >= 0) ? 1'b1 : 1'b0, cfg_par_en && bad_par, bad_stop, dm});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      checks++;
      if (irq_bad != 0) begin
        failures++;
        $display("FAIL R11 irq per-clock mismatches actual=%0d expected=0", irq_bad);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "idle", idle, 1);
    chk("R1", "avail", avail, 0);
    chk("R1", "ferr|perr|nf", {ferr, perr, nf}, 0);
    chk("R1", "oerr", oerr, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "rdata", rdata, 0);
    rst_n = 1'b1;
    ticks(20);

    // R2 8-bit frame, R11 irq with data
    send_frame(9'h0A5, 0, 0, -1);
    compare_model("R2");
    chk("R11", "irq with data", irq, 1);
    rie = 1'b0;
    @(negedge clk);
    chk("R11", "irq masked", irq, 0);
    rie = 1'b1;
    rd_data();
    compare_model("R8");

    // R2 9-bit frame
    cfg_nine = 1'b1;
    send_frame(9'h1C3, 0, 0, -1);
    compare_model("R2");
    rd_data();
    cfg_nine = 1'b0;

    // R4 even parity good then bad; R8 flags of oldest entry
    cfg_par_en = 1'b1;
    send_frame(9'h035, 0, 0, -1);
    send_frame(9'h035, 1, 0, -1);
    compare_model("R4");
    rd_data();
    compare_model("R8");
    rd_data();
    // R4 odd parity good then bad
    cfg_par_odd = 1'b1;
    send_frame(9'h007, 0, 0, -1);
    compare_model("R4");
    rd_data();
    send_frame(9'h0F0, 1, 0, -1);
    compare_model("R4");
    rd_data();
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;

    // R5 framing error
    send_frame(9'h055, 0, 1, -1);
    compare_model("R5");
    rd_data();

    // R3 noise on data bit 2, value kept by majority
    send_frame(9'h03C, 0, 0, 3);
    compare_model("R3");
    rd_data();

    // R3 start glitch: low for 6 ticks only
    for (int t = 0; t < 6; t++) begin
      rxd = 1'b0;
      @(tick_done);
    end
    rxd = 1'b1;
    ticks(40);
    chk("R3", "glitch idle", idle, 1);
    compare_model("R3");

    // R6 break: low for frame length plus 48 ticks
    rxd = 1'b0;
    ticks(10 * 16 + 48);
    chk("R7", "idle during break", idle, 1);
    model_push({1'b0, 1'b0, 1'b1, 9'h000});
    compare_model("R6");
    rxd = 1'b1;
    ticks(48);
    compare_model("R6");
    rd_data();
    compare_model("R6");

    // R9 overrun with three characters
    send_frame(9'h011, 0, 0, -1);
    send_frame(9'h022, 0, 0, -1);
    send_frame(9'h033, 0, 0, -1);
    compare_model("R9");
    chk("R9", "oerr set", oerr, 1);
    // R10 data read without status read keeps oerr
    rd_data();
    compare_model("R10");
    chk("R9", "second kept", rdata, 9'h022);
    rd_stat();
    rd_data();
    compare_model("R10");
    chk("R10", "oerr cleared", oerr, 0);
    chk("R11", "irq idle", irq, 0);

    finish_run();
  end
endmodule